// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a synchronized I2C bus and decides, after every Start or Repeated Start, whether the slave it belongs to is being addressed. It shifts in the address byte on rising SCL edges. Its address may be 7 bits or 10 bits wide. A per-bit mask turns chosen address bits into don't-care bits. It can also answer the all-zero general call, or accept every address. When the address matches, it pulls SDA low for the ninth (acknowledge) clock. When the address does not match, it leaves SDA released and ignores the rest of the transfer until the next Start or Stop.

When a match asks the slave to supply data (read direction), the block holds SCL low after the acknowledge clock. It keeps SCL low until the host logic pulses a release input. The host logic gets a single-cycle match pulse, together with a read/write flag and a general-call flag. Both flags stay valid until the next Start or Stop. Moving data bytes after the address phase is left to other logic.

Top module: `i2c_addr_match`

## Requirements
- R1: A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. A Stop clears `rw_o`, `gc_o`, `sda_low_o`, `scl_low_o` and any stored 10-bit address match.
- R2: In 7-bit mode (`cfg_ten_bit_i`=0), the first byte after a Start is taken as address bits [7:1] and R/W bit [0], sent MSB first. When it matches, `sda_low_o` is high throughout the ninth SCL high phase (ACK). When it does not match, SDA stays released (NACK).
- R3: A 1 in `cfg_mask_i[k]` makes address bit k a don't-care bit in the compare. In 7-bit mode the compare uses `cfg_addr_i[6:0]` and `cfg_mask_i[6:0]`.
- R4: When `cfg_gc_en_i`=1, the byte 0x00 is acknowledged and gives a match with `gc_o`=1 and `rw_o`=0. When `cfg_gc_en_i`=0, the byte 0x00 is treated as an ordinary address.
- R5: When `cfg_match_all_i`=1, every first byte is acknowledged and gives a match, whatever its value.
- R6: In 10-bit mode, a header byte 11110 a9 a8 0 whose a9 and a8 match `cfg_addr_i[9:8]` (masked) is acknowledged without a match pulse. If the next byte matches `cfg_addr_i[7:0]` (masked), it is acknowledged, gives a match with `rw_o`=0, and stores a valid full-address match. If it does not match, it is NACKed and the stored match is cleared.
- R7: In 10-bit mode, a header byte 11110 a9 a8 1 is acknowledged, and gives a match with `rw_o`=1, only if the stored full-address match is valid. Otherwise it is NACKed.
- R8: `match_o` is a one-cycle pulse for each match. `rw_o` and `gc_o` take that match's values and keep them until the next Start or Stop.
- R9: After a match with `rw_o`=1, `scl_low_o` rises at the end of the ninth clock. It stays high until `release_i` is pulsed, and is low from the cycle after the pulse.
- R10: After reset, `sda_low_o`, `scl_low_o`, `match_o`, `rw_o` and `gc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL bus level |
| sda_i | input | 1 | Synchronized SDA bus level |
| cfg_ten_bit_i | input | 1 | 1 = 10-bit address format, 0 = 7-bit |
| cfg_addr_i | input | 10 | Own slave address; 7-bit mode uses [6:0] |
| cfg_mask_i | input | 10 | 1 = the matching address bit is don't-care |
| cfg_gc_en_i | input | 1 | Enables the general call address |
| cfg_match_all_i | input | 1 | Acknowledges every address |
| release_i | input | 1 | Single-cycle pulse that ends clock stretching |
| sda_low_o | output | 1 | Pull SDA low (ACK drive) |
| scl_low_o | output | 1 | Hold SCL low (clock stretch request) |
| match_o | output | 1 | One-cycle address match pulse |
| rw_o | output | 1 | R/W bit of the last match (1 = read) |
| gc_o | output | 1 | Last match was a general call |

## Verification
The ACK decision is registered one system clock after the eighth falling SCL edge is seen. The bench therefore samples the wired-AND SDA level two clocks into the ninth SCL high phase, long after `sda_low_o` has settled. The match pulse appears in that same decision cycle, and a negative-edge monitor counts it. `rw_o` and `gc_o` are compared after the ninth clock, before the Stop. `scl_low_o` is sampled four clocks after the ninth falling edge, which is well past its one-clock latency, and again two clocks after the release pulse.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned A7_W   = 7;
  localparam int unsigned HI_W   = ADDR_W - BYTE_W;
  localparam int unsigned HDR_W  = BYTE_W - HI_W - 1;
  localparam logic [HDR_W-1:0] HDR_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            scl_rise_i,
  input  logic            sda_i,
  output logic [BITS-1:0] byte_o,
  output logic            full_o
);
  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (en_i && scl_rise_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[BITS-2:0], sda_i};
    end
  end

  assign byte_o = sh_q;
  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              phase2_i,
  input  logic              ten_valid_i,
  input  logic              cfg_ten_bit_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic              cfg_gc_en_i,
  input  logic              cfg_match_all_i,
  output logic              ack_o,
  output logic              final_o,
  output logic              rw_o,
  output logic              gc_o,
  output logic              hdr_wr_o,
  output logic              next2_o
);
  logic is_gc, is_hdr, hi_ok, lo_ok, a7_ok;

  assign is_gc  = cfg_gc_en_i && (byte_i == '0);
  assign is_hdr = (byte_i[BYTE_W-1 -: HDR_W] == HDR_TAG);
  assign hi_ok  = ((byte_i[HI_W:1] ^ cfg_addr_i[ADDR_W-1:BYTE_W]) &
                   ~cfg_mask_i[ADDR_W-1:BYTE_W]) == '0;
  assign lo_ok  = ((byte_i ^ cfg_addr_i[BYTE_W-1:0]) & ~cfg_mask_i[BYTE_W-1:0]) == '0;
  assign a7_ok  = ((byte_i[BYTE_W-1:1] ^ cfg_addr_i[A7_W-1:0]) &
                   ~cfg_mask_i[A7_W-1:0]) == '0;

  assign hdr_wr_o = cfg_ten_bit_i && !phase2_i && is_hdr && !byte_i[0];

  always_comb begin
    ack_o   = 1'b0;
    final_o = 1'b0;
    rw_o    = byte_i[0];
    gc_o    = 1'b0;
    next2_o = 1'b0;
    if (phase2_i) begin
      ack_o   = lo_ok || cfg_match_all_i;
      final_o = ack_o;
      rw_o    = 1'b0;
    end else if (is_gc) begin
      ack_o   = 1'b1;
      final_o = 1'b1;
      gc_o    = 1'b1;
      rw_o    = 1'b0;
    end else if (!cfg_ten_bit_i) begin
      ack_o   = a7_ok || cfg_match_all_i;
      final_o = ack_o;
    end else if (is_hdr && !byte_i[0]) begin
      ack_o   = hi_ok || cfg_match_all_i;
      next2_o = ack_o;
    end else if (is_hdr) begin
      ack_o   = (hi_ok && ten_valid_i) || cfg_match_all_i;
      final_o = ack_o;
    end else begin
      ack_o   = cfg_match_all_i;
      final_o = ack_o;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cfg_ten_bit_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic              cfg_gc_en_i,
  input  logic              cfg_match_all_i,
  input  logic              release_i,
  output logic              sda_low_o,
  output logic              scl_low_o,
  output logic              match_o,
  output logic              rw_o,
  output logic              gc_o
);
  logic start, stop, scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_full, sh_clr;
  logic c_ack, c_final, c_rw, c_gc, c_hdr_wr, c_next2;

  st_e  st_q;
  logic phase2_q, ten_valid_q, next2_q, hold_pend_q;
  logic sda_low_q, scl_low_q, match_q, rw_q, gc_q;

  i2c_am_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  assign sh_clr = start || stop || (st_q == ST_ACK && scl_fall && next2_q);

  i2c_am_shift #(.BITS(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sh_clr),
    .en_i       (st_q == ST_RX),
    .scl_rise_i (scl_rise),
    .sda_i      (sda_i),
    .byte_o     (rx_byte),
    .full_o     (rx_full)
  );

  i2c_am_cmp u_cmp (
    .byte_i          (rx_byte),
    .phase2_i        (phase2_q),
    .ten_valid_i     (ten_valid_q),
    .cfg_ten_bit_i   (cfg_ten_bit_i),
    .cfg_addr_i      (cfg_addr_i),
    .cfg_mask_i      (cfg_mask_i),
    .cfg_gc_en_i     (cfg_gc_en_i),
    .cfg_match_all_i (cfg_match_all_i),
    .ack_o           (c_ack),
    .final_o         (c_final),
    .rw_o            (c_rw),
    .gc_o            (c_gc),
    .hdr_wr_o        (c_hdr_wr),
    .next2_o         (c_next2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      phase2_q    <= 1'b0;
      ten_valid_q <= 1'b0;
      next2_q     <= 1'b0;
      hold_pend_q <= 1'b0;
      sda_low_q   <= 1'b0;
      scl_low_q   <= 1'b0;
      match_q     <= 1'b0;
      rw_q        <= 1'b0;
      gc_q        <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (stop) begin
        st_q        <= ST_IDLE;
        phase2_q    <= 1'b0;
        ten_valid_q <= 1'b0;
        sda_low_q   <= 1'b0;
        scl_low_q   <= 1'b0;
        rw_q        <= 1'b0;
        gc_q        <= 1'b0;
      end else if (start) begin
        st_q      <= ST_RX;
        phase2_q  <= 1'b0;
        sda_low_q <= 1'b0;
        scl_low_q <= 1'b0;
        rw_q      <= 1'b0;
        gc_q      <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (rx_full && scl_fall) begin
              // a fresh 10-bit write header invalidates any earlier full match
              if (c_hdr_wr || phase2_q) ten_valid_q <= phase2_q && c_ack;
              if (c_ack) begin
                st_q        <= ST_ACK;
                sda_low_q   <= 1'b1;
                next2_q     <= c_next2;
                hold_pend_q <= c_final && c_rw;
                if (c_final) begin
                  match_q <= 1'b1;
                  rw_q    <= c_rw;
                  gc_q    <= c_gc;
                end
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_low_q <= 1'b0;
              if (next2_q) begin
                st_q     <= ST_RX;
                phase2_q <= 1'b1;
              end else if (hold_pend_q) begin
                st_q      <= ST_HOLD;
                scl_low_q <= 1'b1;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_HOLD: begin
            if (release_i) begin
              scl_low_q <= 1'b0;
              st_q      <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low_o = sda_low_q;
  assign scl_low_o = scl_low_q;
  assign match_o   = match_q;
  assign rw_o      = rw_q;
  assign gc_o      = gc_q;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic release_i,
  input logic sda_low_o,
  input logic scl_low_o,
  input logic match_o,
  input logic rw_o,
  input logic gc_o
);
  logic scl_d, sda_d, bus_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign bus_stop = scl_d & scl_i & ~sda_d & sda_i;

  assert_stop_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stop |=> (!rw_o && !gc_o && !sda_low_o && !scl_low_o));

  assert_ack_drive_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_i);

  assert_gc_is_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_o |-> !rw_o);

  assert_match_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  assert_hold_only_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> rw_o);

  assert_release_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_o && release_i) |=> !scl_low_o);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (.*);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic cfg_ten_bit = 1'b0, cfg_gc_en = 1'b0, cfg_match_all = 1'b0, release_p = 1'b0;
  logic [9:0] cfg_addr = '0, cfg_mask = '0;
  logic sda_low, scl_low, match, rw, gc;
  logic sda_bus, scl_bus;
  int n_cmp = 0, n_bad = 0, n_match = 0;

  always #2.5ns clk = ~clk;

  assign sda_bus = sda_m & ~sda_low;
  assign scl_bus = scl_m & ~scl_low;

  i2c_addr_match uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_bus), .sda_i(sda_bus),
    .cfg_ten_bit_i(cfg_ten_bit), .cfg_addr_i(cfg_addr), .cfg_mask_i(cfg_mask),
    .cfg_gc_en_i(cfg_gc_en), .cfg_match_all_i(cfg_match_all), .release_i(release_p),
    .sda_low_o(sda_low), .scl_low_o(scl_low), .match_o(match), .rw_o(rw), .gc_o(gc)
  );

  always @(negedge clk) if (match) n_match++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2);
    scl_m = 1'b1; tick(3);
    sda_m = 1'b0; tick(3);
    scl_m = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(3);
    scl_m = 1'b1; tick(3);
    sda_m = 1'b1; tick(3);
  endtask

  // sends one byte, returns ACK seen on the bus and stretch state after clock 9
  task automatic send_byte(input logic [7:0] b, output logic ack, output logic hold);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(3);
      scl_m = 1'b1; tick(3);
      scl_m = 1'b0; tick(3);
    end
    sda_m = 1'b1; tick(3);
    scl_m = 1'b1; tick(2);
    ack = ~sda_bus;
    tick(1);
    scl_m = 1'b0; tick(4);
    hold = scl_low;
  endtask

  task automatic do_release(input string req);
    release_p = 1'b1; tick(1);
    release_p = 1'b0; tick(1);
    chk(scl_low == 1'b0, req, scl_low, 0);
  endtask

  // single-byte transaction with all observations checked
  task automatic one_byte(input logic [7:0] b, input bit exp_ack, input bit exp_gc, input string req);
    logic ack, hold;
    int m0;
    m0 = n_match;
    bus_start();
    send_byte(b, ack, hold);
    chk(ack == exp_ack, req, ack, exp_ack);
    chk((n_match - m0) == int'(exp_ack), {req, " R8 match count"}, n_match - m0, int'(exp_ack));
    chk(hold == (exp_ack & b[0] & ~exp_gc), {req, " R9 stretch"}, hold, exp_ack & b[0] & ~exp_gc);
    if (exp_ack) begin
      chk(rw == (b[0] & ~exp_gc), {req, " R8 rw"}, rw, b[0] & ~exp_gc);
      chk(gc == exp_gc, {req, " R4 gc"}, gc, exp_gc);
    end
    if (hold) do_release({req, " R9 release"});
    bus_stop();
    chk(rw == 1'b0 && gc == 1'b0, {req, " R1 stop clear"}, {rw, gc}, 0);
  endtask

  initial begin
    logic ack, hold;
    int m0;
    tick(3);
    chk({sda_low, scl_low, match, rw, gc} == 5'b0, "R10 reset", {sda_low, scl_low, match, rw, gc}, 0);
    rst_ni = 1'b1;
    tick(3);
    chk({sda_low, scl_low, match, rw, gc} == 5'b0, "R10 idle", {sda_low, scl_low, match, rw, gc}, 0);

    // R2 R4 sweep: 7-bit, no mask, general call enabled
    cfg_addr = 10'h02A; cfg_mask = '0; cfg_gc_en = 1'b1;
    for (int a = 0; a < 128; a++)
      for (int r = 0; r < 2; r++) begin
        logic [7:0] b;
        bit g;
        b = {a[6:0], r[0]};
        g = (b == 8'h00);
        one_byte(b, g || (a[6:0] == 7'h2A), g, "R2");
      end

    // R3 sweep: mask bits 0 and 2, general call disabled (0x00 ordinary)
    cfg_mask = 10'h005; cfg_gc_en = 1'b0; cfg_addr = 10'h000;
    for (int a = 0; a < 128; a++)
      for (int r = 0; r < 2; r++) begin
        logic [7:0] b;
        b = {a[6:0], r[0]};
        one_byte(b, ((a[6:0] ^ 7'h00) & ~7'h05) == 7'h00, 1'b0, "R3 R4");
      end

    // R5 match-all
    cfg_addr = 10'h02A; cfg_mask = '0; cfg_match_all = 1'b1;
    one_byte(8'h00, 1'b1, 1'b0, "R5");
    one_byte(8'h37, 1'b1, 1'b0, "R5");
    one_byte(8'hFF, 1'b1, 1'b0, "R5");
    cfg_match_all = 1'b0;

    // 10-bit: address 0x2B5 (high bits 10, low byte B5)
    cfg_ten_bit = 1'b1; cfg_addr = 10'h2B5; cfg_mask = '0;
    m0 = n_match;
    bus_start();
    send_byte(8'hF4, ack, hold);
    chk(ack == 1'b1, "R6 header ack", ack, 1);
    chk(n_match == m0, "R6 no match on header", n_match - m0, 0);
    send_byte(8'hB5, ack, hold);
    chk(ack == 1'b1, "R6 low byte ack", ack, 1);
    chk(n_match == m0 + 1, "R6 match", n_match - m0, 1);
    chk(rw == 1'b0 && hold == 1'b0, "R6 write no stretch", {rw, hold}, 0);
    bus_start();
    send_byte(8'hF5, ack, hold);
    chk(ack == 1'b1, "R7 read header ack", ack, 1);
    chk(n_match == m0 + 2, "R7 read match", n_match - m0, 2);
    chk(rw == 1'b1, "R7 rw", rw, 1);
    chk(hold == 1'b1, "R9 read stretch", hold, 1);
    do_release("R9 release 10-bit");
    bus_stop();

    // R1 R7: Stop dropped the stored match
    one_byte(8'hF5, 1'b0, 1'b0, "R1 R7 read after stop");

    // R6 wrong low byte then R7 read refused
    m0 = n_match;
    bus_start();
    send_byte(8'hF4, ack, hold);
    send_byte(8'hB4, ack, hold);
    chk(ack == 1'b0, "R6 low byte nack", ack, 0);
    chk(n_match == m0, "R6 no match", n_match - m0, 0);
    bus_start();
    send_byte(8'hF5, ack, hold);
    chk(ack == 1'b0, "R7 read nack", ack, 0);
    bus_stop();

    // R6 wrong high bits
    one_byte(8'hF2, 1'b0, 1'b0, "R6 header mismatch");
    // R6 masked low bit 0
    cfg_mask = 10'h001;
    m0 = n_match;
    bus_start();
    send_byte(8'hF4, ack, hold);
    send_byte(8'hB4, ack, hold);
    chk(ack == 1'b1 && n_match == m0 + 1, "R3 R6 masked low byte", ack, 1);
    bus_stop();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule